// File: doc/BRIEF.md
# Refresh Row Address Generator

This block produces the dynamic-memory refresh address that a processor core sends out during each opcode fetch. It holds an 8-bit refresh register. Only the lower seven bits act as a row counter: they advance by one after every completed opcode fetch and wrap from 127 back to 0. The top bit changes only when software writes the register through the load port.

In the third and fourth clock states of an opcode-fetch machine cycle, the block drives the current row number onto the low address lines. In the same window it pulls the refresh flag and a memory-request strobe low, so that every attached memory device can run a row-only refresh. In all other states the strobes are idle and the address drive is off.

Top module: `rfsh_addr_gen`

## Requirements
- R1: While `rst_n` is low the register clears to 0x00, and `reg_val` reads 0x00 after reset.
- R2: A clock edge with `fetch_done` high and `load_en` low adds one to `reg_val[6:0]`. The new value is visible from the next cycle onward.
- R3: Stepping the row never changes `reg_val[7]`.
- R4: A step when `reg_val[6:0]` is 127 gives 0 in those bits, with no carry into bit 7.
- R5: A clock edge with `load_en` high writes all eight bits of `load_val` into the register. When `fetch_done` is high on the same edge, the load wins and no step happens.
- R6: A clock edge with `load_en` and `fetch_done` both low leaves the register unchanged.
- R7: When `fetch_cyc` is high and `tstate` is 3 (third state) or 4 (fourth state), the outputs take these values in the same cycle: `rfsh_n` = 0, `rfsh_mreq_n` = 0, `rfsh_addr_oe` = 1, and `rfsh_addr` = `reg_val[6:0]`. The `tstate` encoding is 0 idle, 1 to 4 the clock states, and 5 to 7 unused.
- R8: In every other combination of `fetch_cyc` and `tstate`, `rfsh_n` and `rfsh_mreq_n` are 1, `rfsh_addr_oe` is 0, and `rfsh_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_done | input | 1 | Single-cycle pulse at the end of an opcode fetch |
| fetch_cyc | input | 1 | The current machine cycle is an opcode fetch |
| tstate | input | 3 | Current clock state: 0 idle, 1 to 4 for the first to fourth state |
| load_en | input | 1 | Software write strobe for the register |
| load_val | input | 8 | Value written when `load_en` is high |
| reg_val | output | 8 | Current register contents |
| rfsh_addr | output | 7 | Refresh row on the low address lines, 0 when not driven |
| rfsh_addr_oe | output | 1 | Address drive enable for the refresh row |
| rfsh_n | output | 1 | Active-low refresh flag |
| rfsh_mreq_n | output | 1 | Active-low memory request used as the refresh row strobe |

## Verification
The bench goes after the wrap at 127 with bit 7 set. A design that lets the carry ripple upward would flip the top bit, or would step a 0xFF register to 0x00 instead of 0x80. It also drives a load and a fetch pulse on the same edge, where a wrong priority would leave the loaded value off by one. It sweeps every `tstate` code with and without `fetch_cyc`, which exposes a window that opens in the first or second state, ignores the fetch qualifier, or leaves a stale row on the address lines while the drive is off. Random load values, pulses and states mixed between these cases check the register against a bench model on every cycle.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_T4   = 3'd4
    } tstate_e;

    // True in the two clock states of a fetch that are given to refresh
    function automatic logic in_refresh_state(input logic [2:0] ts);
        return (ts == TS_T3) || (ts == TS_T4);
    endfunction

endpackage

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int REG_BITS = 8,
    parameter int ROW_BITS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                load_en,
    input  logic [REG_BITS-1:0] load_val,
    output logic [REG_BITS-1:0] reg_q
);

    localparam int TOP_BITS = REG_BITS - ROW_BITS;
    localparam logic [ROW_BITS-1:0] ROW_MAX = ROW_BITS'((1 << ROW_BITS) - 1);

    typedef struct packed {
        logic [TOP_BITS-1:0] top;
        logic [ROW_BITS-1:0] row;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.top = load_val[REG_BITS-1:ROW_BITS];
            st_d.row = load_val[ROW_BITS-1:0];
        end else if (step) begin
            // Wraps by width; the upper field takes no part in counting
            st_d.row = st_q.row + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_q = st_q;

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en) |=> (st_q.row == ROW_BITS'($past(st_q.row) + 1))); // R2
    AST_TOP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en) |=> $stable(st_q.top)); // R3
    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en && st_q.row == ROW_MAX) |=> (st_q.row == '0)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (reg_q == $past(load_val))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step) |=> $stable(reg_q)); // R6

endmodule

// File: rtl/rfsh_window.sv
module rfsh_window
    import rfsh_pkg::*;
#(
    parameter int ROW_BITS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_cyc,
    input  logic [2:0]          tstate,
    input  logic [ROW_BITS-1:0] row,
    output logic [ROW_BITS-1:0] addr,
    output logic                addr_oe,
    output logic                rfsh_n,
    output logic                mreq_n
);

    logic win;

    always_comb begin
        win     = fetch_cyc && in_refresh_state(tstate);
        addr_oe = win;
        rfsh_n  = !win;
        mreq_n  = !win;
        addr    = win ? row : '0;
    end

    AST_STROBES_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_n == mreq_n) && (addr_oe == !rfsh_n)); // R7
    AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == TS_T1 || tstate == TS_T2 || !fetch_cyc) |-> (rfsh_n && !addr_oe)); // R8
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_oe) |-> (addr == '0)); // R8
    AST_ROW_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> (addr == row)); // R7

endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen #(
    parameter int REG_BITS = 8,
    parameter int ROW_BITS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fetch_done,
    input  logic                fetch_cyc,
    input  logic [2:0]          tstate,
    input  logic                load_en,
    input  logic [REG_BITS-1:0] load_val,
    output logic [REG_BITS-1:0] reg_val,
    output logic [ROW_BITS-1:0] rfsh_addr,
    output logic                rfsh_addr_oe,
    output logic                rfsh_n,
    output logic                rfsh_mreq_n
);

    logic [REG_BITS-1:0] reg_q;

    rfsh_row_counter #(
        .REG_BITS(REG_BITS),
        .ROW_BITS(ROW_BITS)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (fetch_done),
        .load_en (load_en),
        .load_val(load_val),
        .reg_q   (reg_q)
    );

    rfsh_window #(
        .ROW_BITS(ROW_BITS)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .fetch_cyc(fetch_cyc),
        .tstate   (tstate),
        .row      (reg_q[ROW_BITS-1:0]),
        .addr     (rfsh_addr),
        .addr_oe  (rfsh_addr_oe),
        .rfsh_n   (rfsh_n),
        .mreq_n   (rfsh_mreq_n)
    );

    assign reg_val = reg_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (reg_val == '0)); // R1

endmodule

// File: tb/rfsh_addr_gen_test.sv
`timescale 1ns/1ps
module rfsh_addr_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_done = 1'b0;
    logic       fetch_cyc = 1'b0;
    logic [2:0] tstate = 3'd0;
    logic       load_en = 1'b0;
    logic [7:0] load_val = 8'h00;
    logic [7:0] reg_val;
    logic [6:0] rfsh_addr;
    logic       rfsh_addr_oe, rfsh_n, rfsh_mreq_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rfsh_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .fetch_done(fetch_done), .fetch_cyc(fetch_cyc),
        .tstate(tstate), .load_en(load_en), .load_val(load_val), .reg_val(reg_val),
        .rfsh_addr(rfsh_addr), .rfsh_addr_oe(rfsh_addr_oe), .rfsh_n(rfsh_n),
        .rfsh_mreq_n(rfsh_mreq_n)
    );

    function automatic logic [7:0] next_reg(input logic [7:0] r, input logic ld,
                                            input logic [7:0] lv, input logic fd);
        if (ld) return lv;
        if (fd) return {r[7], 7'(r[6:0] + 7'd1)};
        return r;
    endfunction

    function automatic logic in_win(input logic fc, input logic [2:0] ts);
        return fc && (ts == 3'd3 || ts == 3'd4);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string rtag);
        logic w;
        w = in_win(fetch_cyc, tstate);
        check({rtag, " reg"}, reg_val, model);
        if (w) begin
            check("R7 rfsh_n", rfsh_n, 0);
            check("R7 mreq_n", rfsh_mreq_n, 0);
            check("R7 oe", rfsh_addr_oe, 1);
            check("R7 addr", rfsh_addr, model[6:0]);
        end else begin
            check("R8 strobes", {rfsh_n, rfsh_mreq_n, rfsh_addr_oe}, 3'b110);
            check("R8 addr", rfsh_addr, 0);
        end
    endtask

    // Apply inputs after a falling edge, check, then let the rising edge act
    task automatic cycle(input logic fd, input logic fc, input logic [2:0] ts,
                         input logic ld, input logic [7:0] lv, input string rtag);
        @(negedge clk);
        fetch_done = fd; fetch_cyc = fc; tstate = ts; load_en = ld; load_val = lv;
        #2;
        check_outputs(rtag);
        @(posedge clk);
        model = next_reg(model, ld, lv, fd);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset value", reg_val, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 after release", reg_val, 8'h00);

        // R2 basic steps
        for (int i = 0; i < 3; i++) cycle(1, 0, 3'd0, 0, 8'h00, "R2");
        cycle(0, 0, 3'd0, 0, 8'h00, "R2");
        check("R2 three steps", reg_val, 8'h03);

        // R6 hold across idle cycles
        for (int i = 0; i < 4; i++) cycle(0, 0, 3'd0, 0, 8'h00, "R6");
        check("R6 held", reg_val, 8'h03);

        // R4 and R3: wrap with the top bit set
        cycle(0, 0, 3'd0, 1, 8'hFF, "R5");
        cycle(1, 0, 3'd0, 0, 8'h00, "R4");
        cycle(0, 0, 3'd0, 0, 8'h00, "R4");
        check("R4 wrap keeps bit7", reg_val, 8'h80);
        cycle(0, 0, 3'd0, 1, 8'h7F, "R5");
        cycle(1, 0, 3'd0, 0, 8'h00, "R3");
        cycle(0, 0, 3'd0, 0, 8'h00, "R3");
        check("R3 no carry into bit7", reg_val, 8'h00);

        // R5 load beats step on the same edge
        cycle(1, 0, 3'd0, 1, 8'hA5, "R5");
        cycle(0, 0, 3'd0, 0, 8'h00, "R5");
        check("R5 load priority", reg_val, 8'hA5);

        // R7 / R8 sweep over every tstate code with and without a fetch cycle
        for (int f = 0; f < 2; f++)
            for (int t = 0; t < 8; t++)
                cycle(0, f[0], 3'(t), 0, 8'h00, (f == 1 && (t == 3 || t == 4)) ? "R7" : "R8");

        // A full fetch sequence ending in a pulse
        cycle(0, 1, 3'd1, 0, 8'h00, "R8");
        cycle(0, 1, 3'd2, 0, 8'h00, "R8");
        cycle(0, 1, 3'd3, 0, 8'h00, "R7");
        cycle(1, 1, 3'd4, 0, 8'h00, "R7");
        cycle(0, 0, 3'd0, 0, 8'h00, "R2");
        check("R2 after fetch", reg_val, 8'hA6);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic ld;
            ld = ($urandom_range(0, 15) == 0);
            cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  3'($urandom_range(0, 7)), ld, 8'($urandom), "R2");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule